// File: doc/BRIEF.md
# Receiver Lock and Frequency-Sweep Controller

This block sits beside a clock and data recovery loop and runs its acquisition and status logic. It watches the value held in the loop's frequency integrator. When the integrator stays pinned against one end of its range, the block takes this to mean that no data is arriving. While the loop is not phase locked, the block produces a signed sweep term. The loop adds this term into the integrator's summing node once per word clock, so the integrator ramps through the frequency range in search of the data rate. The sweep turns around each time the integrator pins at the end it is heading toward. The sweep term goes to zero as soon as phase lock is reported.

A single lock flag is raised only when three things hold together: the carrier is present, the loop is phase locked, and the integrator does not show a missing input. While this flag is low, the 20-bit parallel output word is muted by freezing it at its last value. A bypass select routes the unretimed word straight to the output around the mute. The lock flag is still computed and reported while bypass is selected. The word clock keeps running throughout, so the muted output is simply a register that is not reloaded.

Top module: `lock_sweep_ctrl`

## Requirements
- R1: After reset, lock_o is 0, data_o is all zeros, and the sweep direction is upward, so sweep_o equals +step_i while phase_lock_i is low.
- R2: An integrator end is near when the top SAT_SHIFT (default 8) bits of integ_i are all ones (high end) or all zeros (low end). That end counts as saturated once integ_i has been near it on SAT_CNT (default 32) consecutive clock edges. Any edge on which integ_i is not near restarts the count.
- R3: While phase_lock_i is low, sweep_o (STEP_W+1 bits, two's complement) equals +step_i when the direction is upward and -step_i when it is downward. The value of step_i is taken live in every clock.
- R4: The sweep reverses on the clock edge after its end has been saturated: upward turns downward at the high end, and downward turns upward at the low end. With integ_i held near that end from some edge onward, the flip takes effect on edge SAT_CNT+1 of the run.
- R5: While phase_lock_i is high, sweep_o is zero and the sweep direction does not change.
- R6: lock_o is a registered flag, one clock behind its inputs. It is 1 only when carrier_i is 1, phase_lock_i is 1, and neither integrator end is saturated.
- R7: When bypass_i is 0 and the lock condition is false at a clock edge, data_o keeps its previous value at that edge, whatever word_i carries.
- R8: When bypass_i is 0 and the lock condition is true at a clock edge, data_o takes word_i at that edge.
- R9: When bypass_i is 1, data_o takes raw_i at every edge whatever the lock state, and lock_o is still produced per R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock, free running |
| rst_n | input | 1 | Asynchronous reset, active low |
| integ_i | input | INT_W (16) | Present frequency integrator value, unsigned |
| phase_lock_i | input | 1 | Phase lock indication from the loop |
| carrier_i | input | 1 | Carrier present indication |
| bypass_i | input | 1 | 1 selects the unretimed word around the mute |
| step_i | input | STEP_W (8) | Sweep step magnitude |
| word_i | input | DATA_W (20) | Retimed parallel word |
| raw_i | input | DATA_W (20) | Unretimed parallel word |
| sweep_o | output | STEP_W+1 (9) | Signed sweep term for the integrator summing node |
| lock_o | output | 1 | Combined lock status |
| data_o | output | DATA_W (20) | Parallel output, held while muted |

## Verification
The bench targets the edges of the saturation window. A value one code below the near-high band must never count. A run one edge short of the window, followed by a single break, must not reverse the sweep. A full run must flip the sign on exactly the edge after the window fills. A design with an off-by-one count, or with a band decode one code too wide, flips early or late, or flips on a value that should never count. The bench also holds a pinned integrator while carrier and phase lock are both high, to catch a lock flag that ignores the no-data state. It then releases the pin and expects lock one edge later than a naive design would give. Finally, it leaves bypass while unlocked, to catch a mute register that falls back to zeros or to the retimed word instead of keeping the last word it actually drove.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

   // Direction of the frequency search ramp.
   typedef enum logic {
      SWEEP_DN = 1'b0,
      SWEEP_UP = 1'b1
   } sweep_dir_t;

   // Index of each integrator end in the detector array.
   localparam int END_LO = 0;
   localparam int END_HI = 1;
   localparam int N_ENDS = 2;

endpackage

// File: rtl/lsc_end_detect.sv
// Watches one end of the integrator range and reports a saturated end
// after a run of consecutive near-end samples.
module lsc_end_detect #(
   parameter int INT_W     = 16,
   parameter int SAT_SHIFT = 8,
   parameter int SAT_CNT   = 32,
   parameter bit HIGH_END  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INT_W-1:0] integ_i,
   output logic             sat_o
);

   localparam int CNT_W = $clog2(SAT_CNT + 1);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(SAT_CNT);

   logic [SAT_SHIFT-1:0] top_bits;
   logic                 near;
   logic [CNT_W-1:0]     run_cnt;

   assign top_bits = integ_i[INT_W-1 -: SAT_SHIFT];

   // The end being watched picks the band decode.
   generate
      if (HIGH_END) begin : g_hi
         assign near = &top_bits;
      end else begin : g_lo
         assign near = ~|top_bits;
      end
   endgenerate

   // Run length counter; sticks at the top while the value stays near.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (!near) begin
         run_cnt <= '0;
      end else if (run_cnt != CNT_TOP) begin
         run_cnt <= run_cnt + 1'b1;
      end
   end

   assign sat_o = (run_cnt == CNT_TOP);

   // R2
   sat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !near |=> !sat_o);

   // R2
   sat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sat_o) |-> $past(near));

endmodule

// File: rtl/lsc_sweep_gen.sv
// Keeps the search direction and forms the signed sweep term.
module lsc_sweep_gen
   import lsc_pkg::*;
#(
   parameter int STEP_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sat_hi_i,
   input  logic                     sat_lo_i,
   input  logic                     phase_lock_i,
   input  logic [STEP_W-1:0]        step_i,
   output logic signed [STEP_W:0]   sweep_o
);

   sweep_dir_t             dir;
   logic signed [STEP_W:0] mag;

   // Direction turns around only while searching, and only at the end
   // it is heading toward.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir <= SWEEP_UP;
      end else if (!phase_lock_i) begin
         if (dir == SWEEP_UP && sat_hi_i) begin
            dir <= SWEEP_DN;
         end else if (dir == SWEEP_DN && sat_lo_i) begin
            dir <= SWEEP_UP;
         end
      end
   end

   assign mag = $signed({1'b0, step_i});

   always_comb begin
      if (phase_lock_i) begin
         sweep_o = '0;
      end else if (dir == SWEEP_UP) begin
         sweep_o = mag;
      end else begin
         sweep_o = -mag;
      end
   end

   // R5
   dir_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_lock_i |=> $stable(dir));

   // R4
   dir_low_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir == SWEEP_DN && sat_lo_i && !phase_lock_i) |=> dir == SWEEP_UP);

endmodule

// File: rtl/lsc_mute_path.sv
// Output word register: reloads from the retimed word when locked, from
// the raw word under bypass, and otherwise keeps its value.
module lsc_mute_path #(
   parameter int DATA_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock_d_i,
   input  logic              bypass_i,
   input  logic [DATA_W-1:0] word_i,
   input  logic [DATA_W-1:0] raw_i,
   output logic [DATA_W-1:0] data_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o <= '0;
      end else if (bypass_i) begin
         data_o <= raw_i;
      end else if (lock_d_i) begin
         data_o <= word_i;
      end
   end

   // R7
   mute_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass_i && !lock_d_i) |=> $stable(data_o));

   // R8
   pass_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass_i && lock_d_i) |=> data_o == $past(word_i));

   // R9
   bypass_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bypass_i |=> data_o == $past(raw_i));

endmodule

// File: rtl/lock_sweep_ctrl.sv
// Acquisition and status controller for a data recovery loop.
module lock_sweep_ctrl
   import lsc_pkg::*;
#(
   parameter int INT_W     = 16,
   parameter int SAT_SHIFT = 8,
   parameter int SAT_CNT   = 32,
   parameter int STEP_W    = 8,
   parameter int DATA_W    = 20
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [INT_W-1:0]       integ_i,
   input  logic                   phase_lock_i,
   input  logic                   carrier_i,
   input  logic                   bypass_i,
   input  logic [STEP_W-1:0]      step_i,
   input  logic [DATA_W-1:0]      word_i,
   input  logic [DATA_W-1:0]      raw_i,
   output logic signed [STEP_W:0] sweep_o,
   output logic                   lock_o,
   output logic [DATA_W-1:0]      data_o
);

   // Elaboration-time parameter checks.
   initial begin
      band_param_chk: assert (SAT_SHIFT > 0 && SAT_SHIFT < INT_W)
         else $error("SAT_SHIFT must lie between 1 and INT_W-1");
      run_param_chk: assert (SAT_CNT >= 1)
         else $error("SAT_CNT must be at least 1");
      step_param_chk: assert (STEP_W >= 1 && STEP_W < INT_W)
         else $error("STEP_W must be narrower than INT_W");
      data_param_chk: assert (DATA_W >= 1)
         else $error("DATA_W must be at least 1");
   end

   logic [N_ENDS-1:0] sat_end;
   logic              no_data;
   logic              lock_d;

   // One run detector per integrator end.
   generate
      for (genvar e = 0; e < N_ENDS; e++) begin : g_end
         lsc_end_detect #(
            .INT_W     (INT_W),
            .SAT_SHIFT (SAT_SHIFT),
            .SAT_CNT   (SAT_CNT),
            .HIGH_END  (e == END_HI)
         ) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .integ_i (integ_i),
            .sat_o   (sat_end[e])
         );
      end
   endgenerate

   assign no_data = |sat_end;
   assign lock_d  = carrier_i & phase_lock_i & ~no_data;

   lsc_sweep_gen #(
      .STEP_W (STEP_W)
   ) u_sweep (
      .clk          (clk),
      .rst_n        (rst_n),
      .sat_hi_i     (sat_end[END_HI]),
      .sat_lo_i     (sat_end[END_LO]),
      .phase_lock_i (phase_lock_i),
      .step_i       (step_i),
      .sweep_o      (sweep_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_o <= 1'b0;
      end else begin
         lock_o <= lock_d;
      end
   end

   lsc_mute_path #(
      .DATA_W (DATA_W)
   ) u_mute (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock_d_i (lock_d),
      .bypass_i (bypass_i),
      .word_i   (word_i),
      .raw_i    (raw_i),
      .data_o   (data_o)
   );

   // R6
   carrier_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !carrier_i |=> !lock_o);

   // R6
   nodata_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      no_data |=> !lock_o);

   // R6
   lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (carrier_i && phase_lock_i && !no_data) |=> lock_o);

   // R5
   sweep_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_lock_i |-> sweep_o == '0);

   // R4
   high_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_end[END_HI] && !phase_lock_i && sweep_o > 0) |=>
         (phase_lock_i || sweep_o <= 0));

endmodule

// File: tb/sim_lock_sweep_ctrl.sv
module sim_lock_sweep_ctrl;

   typedef struct {
      int    ed;   // expected data, -1 skips
      int    el;   // expected lock, -1 skips
      int    esw;  // expected sweep, 999 skips
      string req;
   } exp_t;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [15:0]        integ = 16'h8000;
   logic               plock = 1'b0;
   logic               carrier = 1'b1;
   logic               bypass = 1'b0;
   logic [7:0]         step = 8'd5;
   logic [19:0]        word = '0;
   logic [19:0]        raw = '0;
   logic signed [8:0]  sweep;
   logic               lock;
   logic [19:0]        data;

   int   checks = 0;
   int   fails = 0;
   int   held = 0;
   bit   done = 1'b0;
   exp_t q[$];

   always #5 clk = ~clk;

   lock_sweep_ctrl u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .integ_i      (integ),
      .phase_lock_i (plock),
      .carrier_i    (carrier),
      .bypass_i     (bypass),
      .step_i       (step),
      .word_i       (word),
      .raw_i        (raw),
      .sweep_o      (sweep),
      .lock_o       (lock),
      .data_o       (data)
   );

   // Monitor: pops each expected item and compares at the falling edge.
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t it;
         it = q.pop_front();
         if (it.ed >= 0) begin
            checks++;
            if (int'(data) != it.ed) begin
               fails++;
               $display("FAIL %s data act=%h exp=%h", it.req, data, it.ed);
            end
         end
         if (it.el >= 0) begin
            checks++;
            if (int'(lock) != it.el) begin
               fails++;
               $display("FAIL %s lock act=%0d exp=%0d", it.req, lock, it.el);
            end
         end
         if (it.esw != 999) begin
            checks++;
            if (int'(sweep) != it.esw) begin
               fails++;
               $display("FAIL %s sweep act=%0d exp=%0d", it.req, sweep, it.esw);
            end
         end
      end
   end

   // Driver: one clock edge, then queue what must be seen after it.
   task automatic tick(input int ed, input int el, input int esw, input string req);
      exp_t it;
      @(posedge clk);
      it.ed = ed; it.el = el; it.esw = esw; it.req = req;
      q.push_back(it);
      @(negedge clk);
      #1;
   endtask

   task automatic direct(input int act, input int exp_v, input string what);
      checks++;
      if (act != exp_v) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", what, act, exp_v);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      direct(int'(lock), 0, "R1 lock");
      direct(int'(data), 0, "R1 data");
      direct(int'(sweep), 5, "R1 sweep");
      #1 rst_n = 1'b1;

      // R7 mute while not phase locked
      for (int i = 0; i < 4; i++) begin
         word = 20'hA0000 + 20'(i);
         tick(0, 0, 5, "R7 R1");
      end

      // R8 pass while locked, R5 sweep zero
      plock = 1'b1;
      for (int i = 0; i < 4; i++) begin
         word = 20'h5A5A0 + 20'(i);
         tick(int'(word), 1, 0, "R8 R5");
         held = int'(word);
      end

      // R6 carrier loss mutes
      carrier = 1'b0;
      for (int i = 0; i < 3; i++) begin
         word = 20'h33330 + 20'(i);
         tick(held, 0, 0, "R6 R7");
      end
      carrier = 1'b1;
      plock = 1'b0;
      for (int i = 0; i < 2; i++) begin
         word = 20'h44440 + 20'(i);
         tick(held, 0, 5, "R6");
      end

      // R9 bypass unlocked, then locked
      bypass = 1'b1;
      for (int i = 0; i < 3; i++) begin
         raw = 20'h0F0F0 + 20'(i);
         tick(int'(raw), 0, 5, "R9");
      end
      plock = 1'b1;
      for (int i = 0; i < 2; i++) begin
         raw = 20'h0E0E0 + 20'(i);
         tick(int'(raw), 1, 0, "R9");
      end
      held = int'(raw);
      bypass = 1'b0;
      plock = 1'b0;
      word = 20'h77777;
      tick(held, 0, 5, "R7 after bypass");

      // R2 one code below the high band never counts
      integ = 16'hFEFF;
      for (int i = 0; i < 40; i++) tick(held, 0, 5, "R2 below band");
      // R2 short run then a break
      integ = 16'hFF00;
      for (int i = 0; i < 31; i++) tick(held, 0, 5, "R2 short run");
      integ = 16'h8000;
      tick(held, 0, 5, "R2 break");
      // R4 full run flips on edge SAT_CNT+1
      integ = 16'hFF00;
      for (int i = 0; i < 32; i++) tick(held, 0, 5, "R4 window");
      tick(held, 0, -5, "R4 flip down");
      for (int i = 0; i < 3; i++) tick(held, 0, -5, "R4 stays down");

      // R3 live step value
      integ = 16'h8000;
      step = 8'd17;
      for (int i = 0; i < 2; i++) tick(held, 0, -17, "R3 step");

      // R4 low end
      integ = 16'h00FF;
      for (int i = 0; i < 32; i++) tick(held, 0, -17, "R4 low window");
      tick(held, 0, 17, "R4 flip up");
      integ = 16'h0000;
      for (int i = 0; i < 3; i++) tick(held, 0, 17, "R4 stays up");

      // R6 no-data blocks lock even with carrier and phase lock
      plock = 1'b1;
      for (int i = 0; i < 3; i++) begin
         word = 20'h12340 + 20'(i);
         tick(held, 0, 0, "R6 no data R5");
      end
      integ = 16'h8000;
      word = 20'h9ABC0;
      tick(held, 0, 0, "R6 release edge");
      word = 20'h9ABC1;
      tick(int'(word), 1, 0, "R6 lock after release");

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule